// File: doc/BRIEF.md
# Nonmaskable Interrupt Request Latch

This block turns an asynchronous, unmaskable interrupt pin into a clean request for an instruction sequencer. The pin passes through a synchronizer chain, and a rising-edge detector follows it. Each low-to-high transition sets a single pending flag. A steady level does not set it again. No enable bit can block the flag, and it keeps no in-service state. It works apart from the maskable interrupt controller and never enters that controller's priority resolution.

The sequencer reads the flag through a take pulse, which is raised only in a cycle where an instruction-boundary strobe is present. The same cycle raises a strobe that clears the maskable interrupt enable flag. The sequencer then acknowledges, and the pending flag drops. Because there is no in-service record, a fresh edge that arrives while the handler for an earlier request is still running is latched again. It is taken at the next boundary, so the interrupt can nest into itself.

Top module: `nmi_latch`

## Requirements
- R1: While reset is asserted and on the first cycle after its release (with the pin low), pending, take_pulse and clr_ie are all low.
- R2: With the default two synchronizer stages, a pin that is first sampled high at rising edge k makes pending read high after rising edge k+2 and not before (it is still low after edge k+1).
- R3: A pin held high for many cycles produces only one request: once that request is acknowledged, pending stays low while the pin remains high.
- R4: A pin pulse that is high for exactly one clock period, seen at a single rising edge, still sets pending.
- R5: take_pulse is high only in a cycle where pending and insn_boundary are both high. A pending request with insn_boundary low waits, and take_pulse stays low.
- R6: clr_ie is high in exactly the cycles where take_pulse is high.
- R7: Once set, pending holds until a rising edge with take_ack high, and it reads low after that edge.
- R8: If a new pin edge is detected in the same cycle as take_ack, pending stays high after that edge.
- R9: The block has no masking input and no in-service state. After a request is taken and acknowledged, a new pin edge sets pending again, and the next boundary raises take_pulse again.
- R10: Several pin edges that all arrive before an acknowledge merge into one pending request. After a single acknowledge, pending stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with clk |
| nmi_pin | input | 1 | Raw asynchronous interrupt pin, active high |
| insn_boundary | input | 1 | Sequencer strobe marking an instruction boundary |
| take_ack | input | 1 | Sequencer acknowledge that clears the pending request |
| pending | output | 1 | A request has been latched and has not yet been acknowledged |
| take_pulse | output | 1 | Take the interrupt now (pending and at a boundary) |
| clr_ie | output | 1 | Clear the maskable interrupt enable flag |

## Verification
The hardest case to reach from the ports is a new edge detected in the very cycle the acknowledge is applied (R8). It requires the edge detector's output, which is two synchronizer stages removed from the pin, to line up with take_ack. The stimulus first settles a pending request and drops the pin. It then raises the pin at a known falling edge and drives take_ack after exactly two rising edges, so that the detected edge and the acknowledge meet at the third. The nested case (R9) uses a similar method: an edge is injected after the acknowledge while the boundary strobe keeps toggling.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
  typedef enum logic {
    REQ_IDLE    = 1'b0,
    REQ_WAITING = 1'b1
  } req_state_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_comb stage_d[i] = async_in;
      end else begin : g_next
        always_comb stage_d[i] = stage_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign sync_out = stage_q[LAST];
endmodule

// File: rtl/nmi_edge.sv
module nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise_out
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = level_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise_out = level_in & ~prev_q;
endmodule

// File: rtl/nmi_pend.sv
module nmi_pend
  import nmi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic ack,
  input  logic boundary,
  output logic pending,
  output logic take,
  output logic clr_ie
);
  req_state_e state_q;
  req_state_e state_d;
  logic       state_en;

  always_comb begin
    state_en = set_req | ack;
    state_d  = state_q;
    if (set_req)  state_d = REQ_WAITING;
    else if (ack) state_d = REQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= REQ_IDLE;
    else if (state_en) state_q <= state_d;
  end

  always_comb begin
    pending = (state_q == REQ_WAITING);
    take    = pending & boundary;
    clr_ie  = take;
  end
endmodule

// File: rtl/nmi_latch.sv
module nmi_latch #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_pin,
  input  logic insn_boundary,
  input  logic take_ack,
  output logic pending,
  output logic take_pulse,
  output logic clr_ie
);
  logic pin_sync;
  logic pin_rise;

  nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (nmi_pin),
    .sync_out (pin_sync)
  );

  nmi_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (pin_sync),
    .rise_out (pin_rise)
  );

  nmi_pend u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_req  (pin_rise),
    .ack      (take_ack),
    .boundary (insn_boundary),
    .pending  (pending),
    .take     (take_pulse),
    .clr_ie   (clr_ie)
  );
endmodule

// File: rtl/nmi_latch_chk.sv
module nmi_latch_chk #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst_n,
  input logic nmi_pin,
  input logic insn_boundary,
  input logic take_ack,
  input logic pending,
  input logic take_pulse,
  input logic clr_ie
);
  logic [SYNC_STAGES:0] pin_hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_hist <= '0;
    else        pin_hist <= {pin_hist[SYNC_STAGES-1:0], nmi_pin};
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !pending && !take_pulse); // R1
  AST_SET_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> pin_hist[SYNC_STAGES]); // R2
  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    take_pulse |-> (pending && insn_boundary)); // R5
  AST_WAIT_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !insn_boundary) |-> !take_pulse); // R5
  AST_CLR_IE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ie == take_pulse); // R6
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !take_ack) |=> pending); // R7
endmodule

bind nmi_latch nmi_latch_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .nmi_pin       (nmi_pin),
  .insn_boundary (insn_boundary),
  .take_ack      (take_ack),
  .pending       (pending),
  .take_pulse    (take_pulse),
  .clr_ie        (clr_ie)
);

// File: tb/nmi_latch_test.sv
module nmi_latch_test;
  localparam int CLK_PERIOD = 10;

  logic clk;
  logic rst_n;
  logic nmi_pin;
  logic insn_boundary;
  logic take_ack;
  logic pending;
  logic take_pulse;
  logic clr_ie;

  int errors = 0;
  int checks = 0;

  nmi_latch #(.SYNC_STAGES(2)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .nmi_pin       (nmi_pin),
    .insn_boundary (insn_boundary),
    .take_ack      (take_ack),
    .pending       (pending),
    .take_pulse    (take_pulse),
    .clr_ie        (clr_ie)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; nmi_pin = 1'b0; insn_boundary = 1'b1; take_ack = 1'b0;
    repeat (3) tick();
    settle();
    chk("R1", "pending in reset", pending, 1'b0);
    chk("R1", "take in reset", take_pulse, 1'b0);
    chk("R1", "clr_ie in reset", clr_ie, 1'b0);
    rst_n = 1'b1;
    tick(); settle();
    chk("R1", "pending after release", pending, 1'b0);
    chk("R1", "take after release", take_pulse, 1'b0);
    insn_boundary = 1'b0;
  endtask

  task automatic t_edge_latency();
    tick();
    nmi_pin = 1'b1;
    tick(); settle(); chk("R2", "pending after edge k", pending, 1'b0);
    tick(); settle(); chk("R2", "pending after edge k+1", pending, 1'b0);
    tick(); settle(); chk("R2", "pending after edge k+2", pending, 1'b1);
  endtask

  task automatic t_take_and_ack();
    repeat (3) tick();
    settle();
    chk("R7", "pending holds without ack", pending, 1'b1);
    chk("R5", "no take off boundary", take_pulse, 1'b0);
    chk("R6", "no clr_ie off boundary", clr_ie, 1'b0);
    insn_boundary = 1'b1;
    settle();
    chk("R5", "take at boundary", take_pulse, 1'b1);
    chk("R6", "clr_ie with take", clr_ie, 1'b1);
    tick();
    insn_boundary = 1'b0; take_ack = 1'b1;
    tick(); settle();
    take_ack = 1'b0;
    chk("R7", "pending cleared by ack", pending, 1'b0);
    repeat (5) tick();
    settle();
    chk("R3", "steady high gives no new request", pending, 1'b0);
    insn_boundary = 1'b1; settle();
    chk("R3", "no take on steady level", take_pulse, 1'b0);
    insn_boundary = 1'b0;
    nmi_pin = 1'b0;
    repeat (3) tick();
  endtask

  task automatic t_short_pulse();
    nmi_pin = 1'b1;
    tick();
    nmi_pin = 1'b0;
    tick(); tick(); settle();
    chk("R4", "one-period pulse latched", pending, 1'b1);
    take_ack = 1'b1; tick(); take_ack = 1'b0; settle();
    chk("R7", "ack clears after pulse", pending, 1'b0);
    repeat (3) tick();
  endtask

  task automatic t_ack_collision();
    nmi_pin = 1'b1; tick(); nmi_pin = 1'b0;
    repeat (4) tick();
    settle();
    chk("R8", "pending before collision", pending, 1'b1);
    nmi_pin = 1'b1;
    tick(); tick();
    take_ack = 1'b1;
    tick(); settle();
    take_ack = 1'b0;
    chk("R8", "edge with ack keeps pending", pending, 1'b1);
    nmi_pin = 1'b0;
    take_ack = 1'b1; tick(); take_ack = 1'b0; settle();
    chk("R7", "later ack clears", pending, 1'b0);
    repeat (3) tick();
  endtask

  task automatic t_nested();
    nmi_pin = 1'b1; tick(); nmi_pin = 1'b0;
    tick(); tick();
    insn_boundary = 1'b1; settle();
    chk("R9", "first take", take_pulse, 1'b1);
    tick();
    insn_boundary = 1'b0; take_ack = 1'b1;
    tick(); take_ack = 1'b0;
    for (int i = 0; i < 4; i++) begin
      insn_boundary = i[0];
      tick();
    end
    insn_boundary = 1'b1; settle();
    chk("R9", "no take while handler idle of requests", take_pulse, 1'b0);
    insn_boundary = 1'b0;
    nmi_pin = 1'b1; tick(); nmi_pin = 1'b0;
    tick(); tick(); settle();
    chk("R9", "new edge in handler re-pends", pending, 1'b1);
    insn_boundary = 1'b1; settle();
    chk("R9", "nested take", take_pulse, 1'b1);
    chk("R6", "nested clr_ie", clr_ie, 1'b1);
    tick();
    insn_boundary = 1'b0; take_ack = 1'b1;
    tick(); take_ack = 1'b0;
    repeat (3) tick();
  endtask

  task automatic t_merge();
    nmi_pin = 1'b1; tick(); nmi_pin = 1'b0;
    tick(); tick();
    nmi_pin = 1'b1; tick(); nmi_pin = 1'b0;
    repeat (4) tick();
    settle();
    chk("R10", "pending after two edges", pending, 1'b1);
    take_ack = 1'b1; tick(); take_ack = 1'b0; settle();
    chk("R10", "single ack clears merged", pending, 1'b0);
    repeat (4) tick();
    settle();
    chk("R10", "stays clear after merge", pending, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_edge_latency();
    t_take_and_ack();
    t_short_pulse();
    t_ack_collision();
    t_nested();
    t_merge();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule